// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 64 level-sensitive, active-high interrupt inputs and steers each one to one of two processor request lines: a normal request (`irq_o`) or a fast request (`fiq_o`). Software reaches it over a simple 32-bit register bus with write strobe, byte address and data lines. Through that bus it can read the synchronised raw input levels and the masked status for each output, and it can read and write the per-source enable and steering words. For each output there is also a register that names the lowest-numbered active source.

The sources are grouped into banks of 32. The parameter `NUM_BANKS` selects one bank (32 sources) or two banks (64 sources). The second bank sits at byte offset 0x20 and above. Software services an interrupt by scanning the set bits of the status words, lower bank first. It then removes the cause at the source, because the controller holds no pending state of its own.

Top module: `intc_dual_out`

## Requirements
- R1: After reset the enable and steering words of every bank are zero, `irq_o` and `fiq_o` are low, and every register reads zero while all sources are low.
- R2: Raw status bit n (offset 0x00, bank 1 at 0x20) shows the level of `src_i[n]` from one clock edge earlier. It stays set while the input is high and clears once the input goes low.
- R3: The enable word (0x04, bank 1 at 0x24) and the steering word (0x08, bank 1 at 0x28) read back the last value written to them. Writes to the raw status, status and highest-source offsets change nothing that can be read.
- R4: The normal status word (0x0C, bank 1 at 0x2C) reads raw AND enable AND NOT steer. The fast status word (0x10, bank 1 at 0x30) reads raw AND enable AND steer. A steer bit of 0 selects the normal output, and an enable bit of 0 masks the source.
- R5: `irq_o` is the OR of all normal status bits and `fiq_o` is the OR of all fast status bits, each delayed by one register.
- R6: The highest-source registers, 0x18 for the normal output and 0x1C for the fast output, hold the index of the lowest-numbered set bit of the matching status words in bits [5:0], with bit 31 set. All other bits are zero. The register reads all-zero when no bit is set.
- R7: With `NUM_BANKS`=2, bit n of every bank-1 register stands for source n+32.
- R8: Offset 0x14, offsets 0x34 and above, and, with `NUM_BANKS`=1, every offset from 0x20 upward read zero. Writes there have no effect. Address bits [1:0] are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32*NUM_BANKS | Level interrupt inputs, active high |
| wr_i | input | 1 | Register write strobe |
| addr_i | input | 8 | Register byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for `addr_i`, combinational |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |

## Verification
A change on `src_i` appears in the raw, status and highest-source registers after one clock edge, and on `irq_o`/`fiq_o` after two. A write to the enable or steering words shows in the registers after the edge that takes the write, and on the request lines one edge later. The bench drives each stimulus on a falling edge and waits two full cycles before it samples anything, so every result has settled when it is checked. It reads registers combinationally a short delay after a falling edge.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int BANK_W = 32;
  localparam int ADDR_W = 8;
  // word index inside a bank window (addr[4:2])
  localparam logic [2:0] LOC_RAW  = 3'd0;
  localparam logic [2:0] LOC_EN   = 3'd1;
  localparam logic [2:0] LOC_SEL  = 3'd2;
  localparam logic [2:0] LOC_IRQS = 3'd3;
  localparam logic [2:0] LOC_FIQS = 3'd4;
  localparam logic [2:0] LOC_HPI  = 3'd6;
  localparam logic [2:0] LOC_HPF  = 3'd7;
endpackage

// File: rtl/intc_bank.sv
module intc_bank
  import intc_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [BANK_W-1:0] src_i,
  input  logic              en_we_i,
  input  logic              sel_we_i,
  input  logic [BANK_W-1:0] wdata_i,
  output logic [BANK_W-1:0] raw_o,
  output logic [BANK_W-1:0] en_o,
  output logic [BANK_W-1:0] sel_o,
  output logic [BANK_W-1:0] irq_st_o,
  output logic [BANK_W-1:0] fiq_st_o
);
  logic [BANK_W-1:0] raw_q, en_q, sel_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      raw_q <= '0;
      en_q  <= '0;
      sel_q <= '0;
    end else begin
      raw_q <= src_i;
      if (en_we_i)  en_q  <= wdata_i;
      if (sel_we_i) sel_q <= wdata_i;
    end
  end

  assign raw_o    = raw_q;
  assign en_o     = en_q;
  assign sel_o    = sel_q;
  assign irq_st_o = raw_q & en_q & ~sel_q;
  assign fiq_st_o = raw_q & en_q & sel_q;

  a_r2_raw_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> raw_q == $past(src_i));
  a_r3_en_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_we_i |=> $stable(en_q));
  a_r3_sel_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_we_i |=> $stable(sel_q));
  a_r4_disjoint: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_st_o & fiq_st_o) == '0 && ((irq_st_o | fiq_st_o) & ~raw_q) == '0);
endmodule

// File: rtl/intc_lowest.sv
module intc_lowest #(
  parameter int W = 64
) (
  input  logic [W-1:0] vec_i,
  output logic         valid_o,
  output logic [5:0]   idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (vec_i[i]) idx_o = 6'(i);
    end
  end
  assign valid_o = |vec_i;
endmodule

// File: rtl/intc_dual_out.sv
module intc_dual_out
  import intc_pkg::*;
#(
  parameter int NUM_BANKS = 2
) (
  input  logic                        clk_i,
  input  logic                        rst_ni,
  input  logic [NUM_BANKS*BANK_W-1:0] src_i,
  input  logic                        wr_i,
  input  logic [ADDR_W-1:0]           addr_i,
  input  logic [BANK_W-1:0]           wdata_i,
  output logic [BANK_W-1:0]           rdata_o,
  output logic                        irq_o,
  output logic                        fiq_o
);
  localparam int N = NUM_BANKS * BANK_W;

  logic [NUM_BANKS-1:0][BANK_W-1:0] raw_w, en_w, sel_w, irq_st, fiq_st;
  logic [NUM_BANKS-1:0]             en_we, sel_we;
  logic [N-1:0]                     irq_flat, fiq_flat;
  logic                             hpi_v, hpf_v;
  logic [5:0]                       hpi_idx, hpf_idx;
  logic [2:0]                       loc;
  logic                             in_win;

  assign loc    = addr_i[4:2];
  assign in_win = (addr_i[7:6] == 2'b00);

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign en_we[b]  = wr_i && in_win && (addr_i[5] == b[0]) && (loc == LOC_EN);
    assign sel_we[b] = wr_i && in_win && (addr_i[5] == b[0]) && (loc == LOC_SEL);
    intc_bank u_bank (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .src_i    (src_i[b*BANK_W +: BANK_W]),
      .en_we_i  (en_we[b]),
      .sel_we_i (sel_we[b]),
      .wdata_i  (wdata_i),
      .raw_o    (raw_w[b]),
      .en_o     (en_w[b]),
      .sel_o    (sel_w[b]),
      .irq_st_o (irq_st[b]),
      .fiq_st_o (fiq_st[b])
    );
  end

  assign irq_flat = irq_st;
  assign fiq_flat = fiq_st;

  intc_lowest #(.W(N)) u_low_irq (.vec_i(irq_flat), .valid_o(hpi_v), .idx_o(hpi_idx));
  intc_lowest #(.W(N)) u_low_fiq (.vec_i(fiq_flat), .valid_o(hpf_v), .idx_o(hpf_idx));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o <= 1'b0;
      fiq_o <= 1'b0;
    end else begin
      irq_o <= |irq_flat;
      fiq_o <= |fiq_flat;
    end
  end

  always_comb begin
    rdata_o = '0;
    if (in_win) begin
      for (int b = 0; b < NUM_BANKS; b++) begin
        if (int'(addr_i[5]) == b) begin
          case (loc)
            LOC_RAW:  rdata_o = raw_w[b];
            LOC_EN:   rdata_o = en_w[b];
            LOC_SEL:  rdata_o = sel_w[b];
            LOC_IRQS: rdata_o = irq_st[b];
            LOC_FIQS: rdata_o = fiq_st[b];
            LOC_HPI:  if (b == 0) rdata_o = {hpi_v, 25'd0, hpi_v ? hpi_idx : 6'd0};
            LOC_HPF:  if (b == 0) rdata_o = {hpf_v, 25'd0, hpf_v ? hpf_idx : 6'd0};
            default:  rdata_o = '0;
          endcase
        end
      end
    end
  end

  a_r5_irq_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> irq_o == $past(|irq_st));
  a_r5_fiq_line: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> fiq_o == $past(|fiq_st));
  a_r6_hp_irq_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpi_v |-> irq_flat[hpi_idx] && (irq_flat & ((N'(1) << hpi_idx) - N'(1))) == '0);
  a_r6_hp_fiq_lowest: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hpf_v |-> fiq_flat[hpf_idx] && (fiq_flat & ((N'(1) << hpf_idx) - N'(1))) == '0);
  a_r3_one_write: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({en_we, sel_we}));
endmodule

// File: tb/tb_intc_dual_out.sv
module tb_intc_dual_out;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic [31:0] src1 = '0;
  logic        wr = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata, rdata1;
  logic        irq, fiq, irq1, fiq1;
  logic [63:0] en_m = '0, sel_m = '0;
  int checks = 0, failures = 0;

  always #5 clk = ~clk;

  intc_dual_out #(.NUM_BANKS(2)) dut (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));
  intc_dual_out #(.NUM_BANKS(1)) dut1 (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src1), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata1), .irq_o(irq1), .fiq_o(fiq1));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d, output logic [31:0] d1);
    addr = a;
    #1;
    d  = rdata;
    d1 = rdata1;
  endtask

  task automatic wreg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  function automatic logic [31:0] hp(input logic [63:0] v);
    for (int i = 0; i < 64; i++) if (v[i]) return 32'h8000_0000 | i;
    return 32'h0;
  endfunction

  task automatic chk_all(input string tag);
    logic [31:0] d, d1;
    logic [63:0] ei, ef;
    ei = src & en_m & ~sel_m;
    ef = src & en_m & sel_m;
    rd(8'h00, d, d1); chk({"R2 raw lo ", tag}, d, src[31:0]);
    rd(8'h20, d, d1); chk({"R7 raw hi ", tag}, d, src[63:32]);
    rd(8'h0C, d, d1); chk({"R4 irqst lo ", tag}, d, ei[31:0]);
    rd(8'h2C, d, d1); chk({"R7 irqst hi ", tag}, d, ei[63:32]);
    rd(8'h10, d, d1); chk({"R4 fiqst lo ", tag}, d, ef[31:0]);
    rd(8'h30, d, d1); chk({"R7 fiqst hi ", tag}, d, ef[63:32]);
    rd(8'h18, d, d1); chk({"R6 hp irq ", tag}, d, hp(ei));
    rd(8'h1C, d, d1); chk({"R6 hp fiq ", tag}, d, hp(ef));
    chk({"R5 irq_o ", tag}, {31'd0, irq}, {31'd0, |ei});
    chk({"R5 fiq_o ", tag}, {31'd0, fiq}, {31'd0, |ef});
  endtask

  task automatic apply(input logic [63:0] v, input string tag);
    @(negedge clk);
    src = v;
    @(negedge clk);
    @(negedge clk);
    chk_all(tag);
  endtask

  task automatic set_masks(input logic [63:0] e, input logic [63:0] s);
    wreg(8'h04, e[31:0]);  wreg(8'h24, e[63:32]);
    wreg(8'h08, s[31:0]);  wreg(8'h28, s[63:32]);
    en_m = e; sel_m = s;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d, d1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int a = 0; a < 64; a++) begin
      rd(8'(a * 4), d, d1);
      chk("R1 reset read", d, 32'h0);
    end
    chk("R1 irq_o reset", {30'd0, irq, fiq}, 32'h0);
    // R1 enables zero: an active source stays masked
    apply(64'h0000_0001_0000_0001, "R1 masked");

    // R3 read-back of enable/steer
    wreg(8'h04, 32'hA5A5_0F0F); wreg(8'h24, 32'h1234_5678);
    wreg(8'h08, 32'hFFFF_0000); wreg(8'h2B, 32'h0F0F_F0F0);
    rd(8'h04, d, d1); chk("R3 en lo", d, 32'hA5A5_0F0F);
    rd(8'h24, d, d1); chk("R3 en hi", d, 32'h1234_5678);
    rd(8'h08, d, d1); chk("R3 sel lo", d, 32'hFFFF_0000);
    rd(8'h29, d, d1); chk("R8 sel hi addr lsbs ignored", d, 32'h0F0F_F0F0);

    // single-source sweep over both steering choices
    set_masks('1, 64'hAAAA_AAAA_5555_5555);
    for (int i = 0; i < 64; i++) apply(64'd1 << i, $sformatf("single %0d", i));
    set_masks('1, ~64'hAAAA_AAAA_5555_5555);
    for (int i = 0; i < 64; i++) apply(64'd1 << i, $sformatf("single inv %0d", i));

    // multi-source patterns with mixed masks
    set_masks(64'hF0F0_00FF_FF00_0F0F, 64'h3333_CCCC_0000_FFFF);
    apply('1, "all on");
    apply(64'hFFFF_FFFF_0000_0000, "upper only");
    apply(64'h0000_0100_8000_0000, "bank edge");
    apply(64'hDEAD_BEEF_0BAD_F00D, "mix");
    set_masks(64'h8000_0000_0000_0000, '0);
    apply(64'h8000_0000_0000_0000, "R7 top source");

    // R3 writes to read-only offsets ignored
    set_masks('1, 64'h0000_FFFF_0000_FFFF);
    apply(64'h0123_4567_89AB_CDEF, "pre ro");
    wreg(8'h00, '1); wreg(8'h0C, '0); wreg(8'h10, '1); wreg(8'h18, '1);
    wreg(8'h1C, '1); wreg(8'h20, '0); wreg(8'h2C, '1); wreg(8'h30, '0);
    @(negedge clk);
    chk_all("R3 ro ignored");

    // R8 reserved offsets
    wreg(8'h14, '1); wreg(8'h34, '1); wreg(8'hFC, '1); wreg(8'h44, '1);
    rd(8'h14, d, d1); chk("R8 0x14", d, 32'h0);
    rd(8'h34, d, d1); chk("R8 0x34", d, 32'h0);
    rd(8'h38, d, d1); chk("R8 0x38", d, 32'h0);
    rd(8'h3C, d, d1); chk("R8 0x3C", d, 32'h0);
    rd(8'h44, d, d1); chk("R8 0x44 alias", d, 32'h0);
    rd(8'hFC, d, d1); chk("R8 0xFC", d, 32'h0);
    rd(8'h04, d, d1); chk("R8 en lo untouched", d, 32'hFFFF_FFFF);

    // R2 level clear
    apply('0, "R2 deassert");

    // R8 single-bank instance: upper window absent
    @(negedge clk);
    src1 = 32'h0000_0040;
    wreg(8'h04, 32'h0000_0040);
    wreg(8'h08, 32'h0);
    wreg(8'h24, '1);
    @(negedge clk);
    rd(8'h00, d, d1); chk("R2 dut1 raw", d1, 32'h0000_0040);
    rd(8'h18, d, d1); chk("R6 dut1 hp irq", d1, 32'h8000_0006);
    rd(8'h1C, d, d1); chk("R6 dut1 hp fiq none", d1, 32'h0);
    chk("R5 dut1 irq_o", {31'd0, irq1}, 32'd1);
    chk("R5 dut1 fiq_o", {31'd0, fiq1}, 32'd0);
    for (int a = 8; a < 16; a++) begin
      rd(8'(a * 4), d, d1);
      chk("R8 dut1 upper zero", d1, 32'h0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule